// File: doc/BRIEF.md
# Slot Window Decoder with Byte-Lane Endian Adaptation

This block sits between a host local bus and four plug-in module slots. The host issues one access per request into one of three windows. The first window is a combined I/O, identification and interrupt-acknowledge window. The second is a 16-bit memory window. The third is an 8-bit memory window. The block splits the address into a slot number, a module space and an offset. It raises one read or write strobe toward the addressed slot and space. It also forwards the offset and the write data, and it registers the returned read data for the host.

The first two windows can each run in big-endian mode. A one-byte access in that mode inverts address bit 0 before decoding. A two-byte access in that mode exchanges the two data bytes on both the write and the read path. A small byte-wide configuration port holds the three per-window mode flags. A vector of installed modules is supplied from outside. An access to an empty slot goes nowhere and reads back as zero.

Top module: `slot_window_decoder`

## Requirements
- R1: After reset all three endian flags are 0 (little-endian), `hrdata` is 0, `hrvalid` is 0, and no strobe is raised while `hreq` is low.
- R2: With `hwin`=0 the slot is `haddr[9:8]` and the space code is `haddr[7:6]`. Code 2 selects ID space with offset `haddr[5:0]`. Code 3 selects INT space with offset `haddr[5:0]`. Codes 0 and 1 select I/O space with offset `haddr[6:0]`. Strobe bit index = slot*5 + kind, with kind I/O=0, ID=1, INT=2, MEM16=3, MEM8=4.
- R3: With `hwin`=1 the slot is `haddr[24:23]`, the kind is MEM16 and `mod_off` is `haddr[22:0]`.
- R4: With `hwin`=2 the slot is `haddr[23:22]`, the kind is MEM8 and `mod_off` is `haddr[21:0]` zero-extended. This window never applies endian adaptation. A two-byte access to it raises no strobe and reads 0.
- R5: When the flag of window 0 or 1 is set, a one-byte access (`hsize2`=0) inverts address bit 0 before decoding.
- R6: When the flag of window 0 or 1 is set, a two-byte access exchanges the two bytes of `hwdata` on `mod_wdata` and of `mod_rdata` on `hrdata`. Otherwise data passes unchanged.
- R7: The flags of windows 0, 1 and 2 are bit 0 of configuration bytes 0x2B, 0x2F and 0x33. A write stores `cfg_wdata[0]` there, and writes to other bytes are ignored. A read of one of these bytes returns the flag in bit 0 with the other bits 0. All other bytes read 0. `cfg_rdata` updates one clock after the read request.
- R8: An access to a slot whose `installed` bit is 0 raises no strobe, and a read from it returns 0.
- R9: Each accepted access raises exactly one bit of `mod_rd_stb` (read) or `mod_wr_stb` (write) for the clock in which `hreq` is high. `mod_size2` follows `hsize2`.
- R10: Every read request sets `hrvalid` for the following clock with the data in `hrdata`. A one-byte read returns `mod_rdata[7:0]` zero-extended.
- R11: `hwin`=3 is not a window: no strobe is raised and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hreq | input | 1 | Host access request, one clock per access |
| hwr | input | 1 | 1 = write, 0 = read |
| hwin | input | 2 | Window select: 0 I/O-ID-INT, 1 MEM16, 2 MEM8 |
| hsize2 | input | 1 | 1 = two-byte access, 0 = one byte |
| haddr | input | 25 | Byte address within the window |
| hwdata | input | 16 | Host write data |
| hrdata | output | 16 | Registered read data |
| hrvalid | output | 1 | Read data valid, one clock after a read request |
| cfg_req | input | 1 | Configuration byte access request |
| cfg_wr | input | 1 | 1 = configuration write |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered configuration read data |
| installed | input | 4 | One bit per slot, 1 = module present |
| mod_rd_stb | output | 20 | Read strobes, index slot*5 + kind |
| mod_wr_stb | output | 20 | Write strobes, index slot*5 + kind |
| mod_off | output | 23 | Offset within the selected module space |
| mod_wdata | output | 16 | Lane-adapted write data |
| mod_size2 | output | 1 | Two-byte access indicator toward the module |
| mod_rdata | input | 16 | Module read data, valid in the strobe cycle |

## Verification
The assertions assume that the module side answers a read in the same cycle as the strobe. They also assume that `hreq` is a one-clock pulse, so a raised strobe never spans two accesses. The assertions take `installed` to be stable across an access and its data return. The bench drives every input at the falling edge, holds `installed` and `mod_rdata` constant around each access, and drops `hreq` after one clock. Configuration writes are issued only between host accesses, which keeps the flag a window sees fixed for the whole access.

// File: rtl/swd_pkg.sv
`timescale 1ns/1ps
package swd_pkg;
  localparam int ADDR_W       = 25;
  localparam int DATA_W       = 16;
  localparam int OFF_W        = 23;
  localparam int SLOT_W       = 2;
  localparam int N_SLOT       = 1 << SLOT_W;
  localparam int N_KIND       = 5;
  localparam int N_WIN        = 3;
  localparam int N_STB        = N_SLOT * N_KIND;
  localparam int IO_SLOT_LSB  = 8;
  localparam int IO_SPC_LSB   = 6;
  localparam int M16_SLOT_LSB = 23;
  localparam int M8_SLOT_LSB  = 22;

  typedef enum logic [2:0] {
    K_IO  = 3'd0,
    K_ID  = 3'd1,
    K_INT = 3'd2,
    K_M16 = 3'd3,
    K_M8  = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    WIN_IO  = 2'd0,
    WIN_M16 = 2'd1,
    WIN_M8  = 2'd2,
    WIN_BAD = 2'd3
  } win_e;

  typedef struct packed {
    logic              ok;
    logic [SLOT_W-1:0] slot;
    kind_e             kind;
    logic [OFF_W-1:0]  off;
  } dec_t;

  // space code of the combined window -> module space
  function automatic kind_e space_kind(input logic [1:0] code);
    case (code)
      2'd2:    return K_ID;
      2'd3:    return K_INT;
      default: return K_IO;
    endcase
  endfunction

  // offset width depends on the space: 7 bits for I/O, 6 for ID/INT
  function automatic logic [OFF_W-1:0] space_off(input kind_e k,
                                                 input logic [6:0] low);
    if (k == K_IO) return OFF_W'(low);
    return OFF_W'(low[5:0]);
  endfunction

  function automatic int unsigned stb_index(input logic [SLOT_W-1:0] slot,
                                            input kind_e k);
    return int'(slot) * N_KIND + int'(k);
  endfunction
endpackage

// File: rtl/swd_lane.sv
`timescale 1ns/1ps
module swd_lane #(
  parameter int DATA_W = 16
) (
  input  logic              swap,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int N_BYTE = DATA_W / 8;

  for (genvar b = 0; b < N_BYTE; b++) begin : g_byte
    assign dout[b*8 +: 8] = swap ? din[(N_BYTE-1-b)*8 +: 8] : din[b*8 +: 8];
  end
endmodule

// File: rtl/swd_decode.sv
`timescale 1ns/1ps
module swd_decode
  import swd_pkg::*;
(
  input  logic [1:0]        win,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  input  logic              be,
  output dec_t              dec,
  output logic              flip
);
  logic [ADDR_W-1:0] a;

  always_comb begin
    // byte-address inversion only on the adaptable windows
    flip = be && !wide && (win == WIN_IO || win == WIN_M16);
    a    = addr;
    a[0] = addr[0] ^ flip;
    dec      = '0;
    dec.kind = K_IO;
    case (win)
      WIN_IO: begin
        dec.ok   = 1'b1;
        dec.slot = a[IO_SLOT_LSB +: SLOT_W];
        dec.kind = space_kind(a[IO_SPC_LSB +: 2]);
        dec.off  = space_off(dec.kind, a[6:0]);
      end
      WIN_M16: begin
        dec.ok   = 1'b1;
        dec.slot = a[M16_SLOT_LSB +: SLOT_W];
        dec.kind = K_M16;
        dec.off  = OFF_W'(a[M16_SLOT_LSB-1:0]);
      end
      WIN_M8: begin
        dec.ok   = !wide;
        dec.slot = a[M8_SLOT_LSB +: SLOT_W];
        dec.kind = K_M8;
        dec.off  = OFF_W'(a[M8_SLOT_LSB-1:0]);
      end
      default: dec.ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/swd_cfg.sv
`timescale 1ns/1ps
module swd_cfg #(
  parameter int          N_FLAG = 3,
  parameter logic [7:0]  BASE   = 8'h2B,
  parameter int          STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [N_FLAG-1:0] flags
);
  logic [N_FLAG-1:0] match;

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    assign match[i] = (addr == 8'(int'(BASE) + i * STRIDE));

    always_ff @(posedge clk) begin
      if (!rst_n)                     flags[i] <= 1'b0;
      else if (req && wr && match[i]) flags[i] <= wdata[0];
    end

    // R7
    flag_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req && wr && match[i] |=> flags[i] == $past(wdata[0]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              rdata <= '0;
    else if (req && !wr)     rdata <= {7'd0, |(match & flags)};
  end
endmodule

// File: rtl/slot_window_decoder.sv
`timescale 1ns/1ps
module slot_window_decoder
  import swd_pkg::*;
#(
  parameter logic [7:0] CFG_BASE   = 8'h2B,
  parameter int         CFG_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hreq,
  input  logic              hwr,
  input  logic [1:0]        hwin,
  input  logic              hsize2,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] hrdata,
  output logic              hrvalid,
  input  logic              cfg_req,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [N_SLOT-1:0] installed,
  output logic [N_STB-1:0]  mod_rd_stb,
  output logic [N_STB-1:0]  mod_wr_stb,
  output logic [OFF_W-1:0]  mod_off,
  output logic [DATA_W-1:0] mod_wdata,
  output logic              mod_size2,
  input  logic [DATA_W-1:0] mod_rdata
);
  logic [N_WIN-1:0]  be_flags;
  logic              be_sel;
  logic              addr_flip;
  logic              lane_swap;
  logic              accept;
  logic [N_STB-1:0]  hit_vec;
  logic [N_SLOT-1:0] slot_busy;
  logic [DATA_W-1:0] rd_lane;
  dec_t              dec;

  swd_cfg #(.N_FLAG(N_WIN), .BASE(CFG_BASE), .STRIDE(CFG_STRIDE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .req(cfg_req), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .flags(be_flags)
  );

  always_comb begin
    be_sel = 1'b0;
    for (int w = 0; w < N_WIN; w++)
      if (hwin == 2'(w)) be_sel = be_flags[w];
  end

  swd_decode u_dec (
    .win(hwin), .addr(haddr), .wide(hsize2), .be(be_sel),
    .dec(dec), .flip(addr_flip)
  );

  // two-byte swap only on the adaptable windows
  assign lane_swap = be_sel && hsize2 && (hwin == WIN_IO || hwin == WIN_M16);

  swd_lane #(.DATA_W(DATA_W)) u_wlane (
    .swap(lane_swap), .din(hwdata), .dout(mod_wdata)
  );
  swd_lane #(.DATA_W(DATA_W)) u_rlane (
    .swap(lane_swap), .din(mod_rdata), .dout(rd_lane)
  );

  assign accept  = hreq && dec.ok && installed[dec.slot];
  assign hit_vec = accept ? (N_STB'(1) << stb_index(dec.slot, dec.kind)) : '0;

  assign mod_rd_stb = hwr ? '0 : hit_vec;
  assign mod_wr_stb = hwr ? hit_vec : '0;
  assign mod_off    = dec.off;
  assign mod_size2  = hsize2;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_busy
    assign slot_busy[s] = |(mod_rd_stb[s*N_KIND +: N_KIND] |
                            mod_wr_stb[s*N_KIND +: N_KIND]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hrvalid <= 1'b0;
      hrdata  <= '0;
    end else begin
      hrvalid <= hreq && !hwr;
      if (hreq && !hwr) begin
        if (!accept)     hrdata <= '0;
        else if (hsize2) hrdata <= rd_lane;
        else             hrdata <= DATA_W'(mod_rdata[7:0]);
      end
    end
  end

  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mod_rd_stb, mod_wr_stb}));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hreq |-> (mod_rd_stb == '0 && mod_wr_stb == '0));

  // R8
  empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_busy & ~installed) == '0);

  // R8
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hreq && !hwr && !installed[dec.slot] |=> hrdata == '0);

  // R10
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hreq && !hwr |=> hrvalid);

  // R4
  narrow_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hreq && hwin == WIN_M8 && hsize2 |-> slot_busy == '0);

  // R4
  narrow_no_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hwin == WIN_M8 |-> !addr_flip && !lane_swap);

  // R11
  bad_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hreq && hwin == WIN_BAD |-> slot_busy == '0);
endmodule

// File: tb/sim_slot_window_decoder.sv
`timescale 1ns/1ps
module sim_slot_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hreq = 1'b0, hwr = 1'b0, hsize2 = 1'b0;
  logic [1:0]  hwin = 2'd0;
  logic [24:0] haddr = '0;
  logic [15:0] hwdata = '0;
  logic [15:0] hrdata;
  logic        hrvalid;
  logic        cfg_req = 1'b0, cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0, cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [3:0]  installed = 4'hF;
  logic [19:0] mod_rd_stb, mod_wr_stb;
  logic [22:0] mod_off;
  logic [15:0] mod_wdata;
  logic        mod_size2;
  logic [15:0] mod_rdata = 16'hC3A5;

  int n_run = 0;
  int n_fail = 0;
  logic [19:0] s_rd, s_wr, s_idle;
  logic [22:0] s_off;
  logic [15:0] s_wdata, s_rdata;
  logic        s_rv, s_sz2;
  logic [7:0]  s_cfg;

  always #10 clk = ~clk;

  slot_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .hreq(hreq), .hwr(hwr), .hwin(hwin),
    .hsize2(hsize2), .haddr(haddr), .hwdata(hwdata), .hrdata(hrdata),
    .hrvalid(hrvalid), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .installed(installed), .mod_rd_stb(mod_rd_stb), .mod_wr_stb(mod_wr_stb),
    .mod_off(mod_off), .mod_wdata(mod_wdata), .mod_size2(mod_size2),
    .mod_rdata(mod_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] bit_at(input int slot, input int kind);
    return 20'(1) << (slot * 5 + kind);
  endfunction

  task automatic acc(input logic [1:0] w, input logic wr, input logic sz2,
                     input logic [24:0] a, input logic [15:0] d);
    @(negedge clk);
    hreq = 1'b1; hwr = wr; hwin = w; hsize2 = sz2; haddr = a; hwdata = d;
    #2;
    s_rd = mod_rd_stb; s_wr = mod_wr_stb; s_off = mod_off;
    s_wdata = mod_wdata; s_sz2 = mod_size2;
    @(negedge clk);
    hreq = 1'b0; hwr = 1'b0;
    #2;
    s_rdata = hrdata; s_rv = hrvalid;
    s_idle = mod_rd_stb | mod_wr_stb;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_req = 1'b1; cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a);
    @(negedge clk);
    cfg_req = 1'b1; cfg_wr = 1'b0; cfg_addr = a;
    @(negedge clk);
    cfg_req = 1'b0;
    #2 s_cfg = cfg_rdata;
  endtask

  task automatic t_reset;
    #2;
    chk("R1 hrdata after reset", 32'(hrdata), 32'h0);
    chk("R1 hrvalid after reset", 32'(hrvalid), 32'h0);
    chk("R1 strobes idle", 32'(mod_rd_stb | mod_wr_stb), 32'h0);
    cfg_read(8'h2B); chk("R1 flag0 reset", 32'(s_cfg), 32'h0);
    cfg_read(8'h2F); chk("R1 flag1 reset", 32'(s_cfg), 32'h0);
    cfg_read(8'h33); chk("R1 flag2 reset", 32'(s_cfg), 32'h0);
  endtask

  task automatic t_io_window;
    acc(2'd0, 1'b0, 1'b0, 25'h235, 16'h0);
    chk("R2 io strobe slot2", 32'(s_rd), 32'(bit_at(2, 0)));
    chk("R2 io offset", 32'(s_off), 32'h35);
    chk("R10 byte read low lane", 32'(s_rdata), 32'h00A5);
    chk("R10 read valid", 32'(s_rv), 32'h1);
    chk("R9 strobe one clock", 32'(s_idle), 32'h0);
    acc(2'd0, 1'b0, 1'b0, 25'h18A, 16'h0);
    chk("R2 id strobe slot1", 32'(s_rd), 32'(bit_at(1, 1)));
    chk("R2 id offset", 32'(s_off), 32'h0A);
    acc(2'd0, 1'b1, 1'b1, 25'h3FF, 16'hBEEF);
    chk("R2 int write strobe slot3", 32'(s_wr), 32'(bit_at(3, 2)));
    chk("R9 no read strobe on write", 32'(s_rd), 32'h0);
    chk("R2 int offset", 32'(s_off), 32'h3F);
    chk("R6 le write passes", 32'(s_wdata), 32'hBEEF);
    chk("R9 size2 forwarded", 32'(s_sz2), 32'h1);
    acc(2'd0, 1'b0, 1'b1, 25'h07F, 16'h0);
    chk("R2 io space1 strobe slot0", 32'(s_rd), 32'(bit_at(0, 0)));
    chk("R2 io seven bit offset", 32'(s_off), 32'h7F);
    chk("R6 le wide read passes", 32'(s_rdata), 32'hC3A5);
  endtask

  task automatic t_mem_windows;
    acc(2'd1, 1'b1, 1'b1, {2'd3, 23'h5A5A5}, 16'h1234);
    chk("R3 m16 write strobe", 32'(s_wr), 32'(bit_at(3, 3)));
    chk("R3 m16 offset", 32'(s_off), 32'h5A5A5);
    chk("R3 m16 write data", 32'(s_wdata), 32'h1234);
    acc(2'd2, 1'b0, 1'b0, {1'b0, 2'd1, 22'h012345}, 16'h0);
    chk("R4 m8 read strobe", 32'(s_rd), 32'(bit_at(1, 4)));
    chk("R4 m8 offset", 32'(s_off), 32'h012345);
    acc(2'd2, 1'b0, 1'b1, {1'b0, 2'd1, 22'h012345}, 16'h0);
    chk("R4 m8 wide no strobe", 32'(s_rd | s_wr), 32'h0);
    chk("R4 m8 wide reads zero", 32'(s_rdata), 32'h0);
    chk("R10 valid on rejected read", 32'(s_rv), 32'h1);
    acc(2'd3, 1'b0, 1'b1, 25'h0, 16'h0);
    chk("R11 bad window no strobe", 32'(s_rd | s_wr), 32'h0);
    chk("R11 bad window reads zero", 32'(s_rdata), 32'h0);
  endtask

  task automatic t_endian;
    cfg_write(8'h2B, 8'hFF);
    cfg_read(8'h2B); chk("R7 flag0 reads one", 32'(s_cfg), 32'h01);
    cfg_read(8'h2C); chk("R7 other byte zero", 32'(s_cfg), 32'h00);
    acc(2'd0, 1'b0, 1'b0, 25'h235, 16'h0);
    chk("R5 be byte offset flipped", 32'(s_off), 32'h34);
    acc(2'd0, 1'b1, 1'b1, 25'h235, 16'h1234);
    chk("R6 be wide write swapped", 32'(s_wdata), 32'h3412);
    chk("R5 wide not flipped", 32'(s_off), 32'h35);
    acc(2'd0, 1'b0, 1'b1, 25'h235, 16'h0);
    chk("R6 be wide read swapped", 32'(s_rdata), 32'hA5C3);
    acc(2'd1, 1'b0, 1'b0, {2'd0, 23'h000101}, 16'h0);
    chk("R7 flag0 not window1", 32'(s_off), 32'h101);
    cfg_write(8'h2F, 8'h01);
    acc(2'd1, 1'b0, 1'b0, {2'd0, 23'h000101}, 16'h0);
    chk("R5 m16 be byte flip", 32'(s_off), 32'h100);
    cfg_write(8'h33, 8'h01);
    cfg_read(8'h33); chk("R7 flag2 reads one", 32'(s_cfg), 32'h01);
    acc(2'd2, 1'b0, 1'b0, {1'b0, 2'd1, 22'h012345}, 16'h0);
    chk("R4 m8 ignores flag", 32'(s_off), 32'h012345);
    cfg_write(8'h2B, 8'hFE);
    cfg_read(8'h2B); chk("R7 flag0 cleared", 32'(s_cfg), 32'h00);
    acc(2'd0, 1'b1, 1'b1, 25'h235, 16'h1234);
    chk("R6 cleared flag no swap", 32'(s_wdata), 32'h1234);
  endtask

  task automatic t_empty_slot;
    installed = 4'b1011;
    acc(2'd0, 1'b0, 1'b1, 25'h235, 16'h0);
    chk("R8 empty slot no strobe", 32'(s_rd | s_wr), 32'h0);
    chk("R8 empty slot reads zero", 32'(s_rdata), 32'h0);
    acc(2'd1, 1'b1, 1'b1, {2'd2, 23'h0}, 16'h5555);
    chk("R8 empty slot write dropped", 32'(s_rd | s_wr), 32'h0);
    acc(2'd1, 1'b0, 1'b1, {2'd3, 23'h0}, 16'h0);
    chk("R8 present slot still served", 32'(s_rd), 32'(bit_at(3, 3)));
    installed = 4'hF;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_io_window();
    t_mem_windows();
    t_endian();
    t_empty_slot();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule